// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell with Ripple Carry

This block is one programmable logic element for a fabric of identical cells. A configuration word holds a sixteen-entry truth table that is indexed by the four data inputs. It also holds two mode bits. One chooses whether the cell output is taken straight from the table or from a flip-flop that samples it on each rising clock edge. The other turns on an arithmetic mode for fast ripple carries.

In arithmetic mode the table output acts as a propagate term P. The carry out is the incoming carry when P is 1 and data input 0 when P is 0. The cell output becomes the sum bit P XOR carry-in, and in registered mode the flip-flop stores that sum bit.

A column of cells linked carry-out to carry-in gives a multi-bit adder or counter with no general routing in the carry path. Loaded with the XOR table on inputs 0 and 1, each cell adds one bit of two operands.

Top module: `carry_logic_cell`

## Requirements
- R1: With cfg_word[16]=0 and cfg_word[17]=0, cell_o equals cfg_word[idx] combinationally, where idx is the 4-bit value of din.
- R2: The table index is formed with din[0] as the least significant bit and din[3] as the most significant, so a table with only bit k set drives cell_o high only when din equals k.
- R3: With cfg_word[16]=1, cell_o shows the value the cell computed at the most recent rising clock edge and does not follow input changes between edges.
- R4: An active-low rst_n clears the flip-flop at once, without waiting for a clock edge. In registered mode cell_o is 0 while reset is held and until the first rising edge after release.
- R5: With cfg_word[17]=0, carry_o is 0 for every din and carry_i.
- R6: With cfg_word[17]=1 and a table output P of 1, carry_o equals carry_i.
- R7: With cfg_word[17]=1 and P of 0, carry_o equals din[0].
- R8: With cfg_word[17]=1 and cfg_word[16]=0, cell_o equals P XOR carry_i combinationally.
- R9: With cfg_word[17]=1 and cfg_word[16]=1, the flip-flop samples P XOR carry_i, and cell_o shows that value one edge later.
- R10: Eight cells configured as 18'h26666 (table 16'h6666, arithmetic mode, unregistered), with a[i] on din[0] and b[i] on din[1], chained carry_o to carry_i, give sum bits on cell_o and the carry out of the top cell equal to a+b+cin.
- R11: The tables 16'h8888, 16'hEEEE, 16'h6666, 16'h5555, 16'h0000 and 16'hFFFF give din[0] AND din[1], din[0] OR din[1], din[0] XOR din[1], NOT din[0], constant 0 and constant 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| cfg_word | input | 18 | [15:0] truth table, [16] registered output, [17] arithmetic mode |
| din | input | 4 | Table select inputs; din[0] is also the carry generate term |
| carry_i | input | 1 | Carry from the cell below |
| cell_o | output | 1 | Cell result: table value or sum, direct or registered |
| carry_o | output | 1 | Carry to the cell above |

## Verification
The bench sweeps every input combination against one-hot tables, so a tree with swapped select levels lights the wrong index. It also drives both carry-in values for every arithmetic case, which catches a carry multiplexer with its legs reversed or a propagate taken from the wrong signal. Registered runs change the inputs between edges and pulse reset in the middle of a clock period. A flip-flop that samples the raw table instead of the sum, or whose reset waits for the clock, would show a stale or late value there. The eight-cell adder is driven with all-ones operands and carry-in set to expose a broken ripple at the top of the column.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  // Mode bits decoded from the top of the configuration word.
  typedef struct packed {
    logic arith_en;   // table output is propagate, cell output is the sum
    logic reg_en;     // cell output taken from the flip-flop
  } lcell_mode_t;

  function automatic lcell_mode_t decode_mode(input logic arith_bit,
                                              input logic reg_bit);
    lcell_mode_t m;
    m.arith_en = arith_bit;
    m.reg_en   = reg_bit;
    return m;
  endfunction

endpackage

// File: rtl/lcell_mux_tree.sv
module lcell_mux_tree #(
  parameter int LUT_K = 4
) (
  input  logic [(1<<LUT_K)-1:0] table_bits,
  input  logic [LUT_K-1:0]      sel,
  output logic                  tree_o
);
  localparam int TBL = 1 << LUT_K;

  // Level lv halves the candidate count using sel[lv].
  genvar lv, mi;
  generate
    for (lv = 0; lv < LUT_K; lv++) begin : g_lvl
      localparam int NMUX = TBL >> (lv + 1);
      logic [NMUX-1:0] s;
      for (mi = 0; mi < NMUX; mi++) begin : g_mux
        if (lv == 0) begin : g_leaf
          assign s[mi] = sel[0] ? table_bits[2*mi+1] : table_bits[2*mi];
        end else begin : g_inner
          assign s[mi] = sel[lv] ? g_lvl[lv-1].s[2*mi+1] : g_lvl[lv-1].s[2*mi];
        end
      end
    end
  endgenerate

  assign tree_o = g_lvl[LUT_K-1].s[0];

endmodule

// File: rtl/lcell_carry.sv
module lcell_carry (
  input  logic prop,
  input  logic gen,
  input  logic carry_i,
  input  logic arith_en,
  output logic carry_o,
  output logic comb_val
);
  always_comb begin
    if (arith_en) begin
      carry_o  = prop ? carry_i : gen;
      comb_val = prop ^ carry_i;
    end else begin
      carry_o  = 1'b0;
      comb_val = prop;
    end
  end
endmodule

// File: rtl/lcell_out_stage.sv
module lcell_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic reg_en,
  output logic q_o
);
  logic q_r;
  logic q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_nxt;
  end

  assign q_o = reg_en ? q_r : d;
endmodule

// File: rtl/carry_logic_cell.sv
module carry_logic_cell #(
  parameter int LUT_K = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<LUT_K)+1:0]       cfg_word,
  input  logic [LUT_K-1:0]            din,
  input  logic                        carry_i,
  output logic                        cell_o,
  output logic                        carry_o
);
  import lcell_pkg::*;

  localparam int TBL       = 1 << LUT_K;
  localparam int REG_BIT   = TBL;
  localparam int ARITH_BIT = TBL + 1;

  lcell_mode_t mode;
  logic        lut_val;
  logic        comb_val;

  assign mode = decode_mode(cfg_word[ARITH_BIT], cfg_word[REG_BIT]);

  lcell_mux_tree #(.LUT_K(LUT_K)) tree_i (
    .table_bits (cfg_word[TBL-1:0]),
    .sel        (din),
    .tree_o     (lut_val)
  );

  lcell_carry carry_i0 (
    .prop     (lut_val),
    .gen      (din[0]),
    .carry_i  (carry_i),
    .arith_en (mode.arith_en),
    .carry_o  (carry_o),
    .comb_val (comb_val)
  );

  lcell_out_stage out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (comb_val),
    .reg_en (mode.reg_en),
    .q_o    (cell_o)
  );

endmodule

// File: rtl/carry_logic_cell_chk.sv
module carry_logic_cell_chk #(
  parameter int LUT_K = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [(1<<LUT_K)+1:0] cfg_word,
  input logic [LUT_K-1:0]      din,
  input logic                  carry_i,
  input logic                  cell_o,
  input logic                  carry_o
);
  localparam int TBL       = 1 << LUT_K;
  localparam int REG_BIT   = TBL;
  localparam int ARITH_BIT = TBL + 1;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_comb_table_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_word[REG_BIT] && !cfg_word[ARITH_BIT]) |-> cell_o == cfg_word[din]);

  assert_reg_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_word[REG_BIT]) |->
      cell_o == $past(cfg_word[ARITH_BIT] ? (cfg_word[din] ^ carry_i) : cfg_word[din]));

  assert_first_edge_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!past_ok && cfg_word[REG_BIT]) |-> cell_o == 1'b0);

  assert_carry_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[ARITH_BIT] |-> carry_o == 1'b0);

  assert_prop_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[ARITH_BIT] && cfg_word[din]) |-> carry_o == carry_i);

  assert_generate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[ARITH_BIT] && !cfg_word[din]) |-> carry_o == din[0]);

  assert_sum_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[ARITH_BIT] && !cfg_word[REG_BIT]) |-> cell_o == (cfg_word[din] ^ carry_i));

endmodule

bind carry_logic_cell carry_logic_cell_chk #(.LUT_K(LUT_K)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_word (cfg_word),
  .din      (din),
  .carry_i  (carry_i),
  .cell_o   (cell_o),
  .carry_o  (carry_o)
);

// File: tb/carry_logic_cell_tb_top.sv
`timescale 1ns/1ps
module carry_logic_cell_tb_top;

  logic        clk;
  logic        rst_n;
  logic [17:0] cfg;
  logic [3:0]  din;
  logic        cin;
  logic        cell_o;
  logic        carry_o;

  int checks;
  int errors;

  carry_logic_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .din(din),
    .carry_i(cin), .cell_o(cell_o), .carry_o(carry_o)
  );

  // Eight-cell ripple adder column (R10)
  localparam logic [17:0] ADD_CFG = 18'h26666;
  logic [7:0] op_a, op_b, ch_sum;
  logic       ch_cin;
  logic [8:0] ch_c;
  assign ch_c[0] = ch_cin;
  for (genvar g = 0; g < 8; g++) begin : g_col
    carry_logic_cell cell_u (
      .clk(clk), .rst_n(rst_n), .cfg_word(ADD_CFG),
      .din({2'b00, op_b[g], op_a[g]}), .carry_i(ch_c[g]),
      .cell_o(ch_sum[g]), .carry_o(ch_c[g+1])
    );
  end

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference: table value by integer index, then mode rules.
  function automatic logic ref_val(input logic [17:0] c, input logic [3:0] d, input logic ci);
    int idx;
    logic p;
    idx = int'(d);
    p = c[idx];
    if (c[17]) return p ^ ci;
    return p;
  endfunction

  function automatic logic ref_carry(input logic [17:0] c, input logic [3:0] d, input logic ci);
    int idx;
    idx = int'(d);
    if (!c[17]) return 1'b0;
    if (c[idx] == 1'b1) return ci;
    return d[0];
  endfunction

  logic model_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_q <= 1'b0;
    else        model_q <= ref_val(cfg, din, cin);
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (cfg=%h din=%h cin=%b)", tag, act, exp, cfg, din, cin);
    end
  endtask

  // Drive after a falling edge, then compare both outputs with the model.
  task automatic step(input string tag, input logic [17:0] c, input logic [3:0] d, input logic ci);
    logic eo;
    @(negedge clk);
    cfg = c; din = d; cin = ci;
    #2;
    eo = c[16] ? model_q : ref_val(c, d, ci);
    check(tag, cell_o, eo);
    check(tag, carry_o, ref_carry(c, d, ci));
  endtask

  task automatic add_check(input logic [7:0] a, input logic [7:0] b, input logic ci);
    logic [8:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; ch_cin = ci;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {8'd0, ci};
    checks++;
    if ({ch_c[8], ch_sum} !== exp) begin
      errors++;
      $display("FAIL R10: %0d+%0d+%0d got %h expected %h", a, b, ci, {ch_c[8], ch_sum}, exp);
    end
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; cfg = 18'h1FFFF; din = 4'h0; cin = 1'b1;
    op_a = 8'h0; op_b = 8'h0; ch_cin = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check("R4 reset", cell_o, 1'b0);
    check("R5 reset", carry_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R4 after release", cell_o, 1'b0);

    // R1: combinational lookup, random tables, all indices
    for (int t = 0; t < 8; t++) begin
      logic [15:0] tb16;
      tb16 = 16'($urandom);
      for (int k = 0; k < 16; k++) step("R1", {2'b00, tb16}, 4'(k), 1'($urandom));
    end
    // R2: one-hot tables pin the index order
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 16; k++) step("R2", {2'b00, 16'(1) << b}, 4'(k), 1'b0);
    // R11: common functions
    for (int k = 0; k < 16; k++) begin
      step("R11 and", 18'h08888, 4'(k), 1'b0);
      step("R11 or",  18'h0EEEE, 4'(k), 1'b0);
      step("R11 xor", 18'h06666, 4'(k), 1'b0);
      step("R11 not", 18'h05555, 4'(k), 1'b0);
      step("R11 zero", 18'h00000, 4'(k), 1'b0);
      step("R11 one", 18'h0FFFF, 4'(k), 1'b0);
    end
    // R5: carry off ignores carry_i and din
    for (int k = 0; k < 32; k++) step("R5", {2'b00, 16'($urandom)}, 4'(k), k[4]);
    // R6 R7 R8: arithmetic mode, every index with both carries
    for (int t = 0; t < 4; t++) begin
      logic [15:0] tb16;
      tb16 = (t == 0) ? 16'h6666 : 16'($urandom);
      for (int k = 0; k < 32; k++) step("R6 R7 R8", {2'b10, tb16}, 4'(k), k[4]);
    end
    // R3: registered mode, inputs change every cycle
    for (int k = 0; k < 40; k++) step("R3", {2'b01, 16'hA5C3}, 4'($urandom), 1'($urandom));
    // R9: registered arithmetic mode captures the sum
    for (int k = 0; k < 40; k++) step("R9", {2'b11, 16'h6666}, 4'($urandom), 1'($urandom));
    // R4: reset in mid-period clears output at once
    step("R4 pre", 18'h1FFFF, 4'h3, 1'b0);
    step("R4 pre", 18'h1FFFF, 4'h3, 1'b0);
    #1 rst_n = 1'b0;
    #1 check("R4 async", cell_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R4 hold", cell_o, 1'b0);
    step("R3 resume", 18'h1FFFF, 4'h3, 1'b0);
    step("R3 resume", 18'h1FFFF, 4'h3, 1'b0);
    // R10: ripple adder
    add_check(8'd0, 8'd0, 1'b0);
    add_check(8'd255, 8'd1, 1'b0);
    add_check(8'd255, 8'd255, 1'b1);
    add_check(8'd0, 8'd255, 1'b1);
    add_check(8'h55, 8'hAA, 1'b1);
    for (int k = 0; k < 40; k++) add_check(8'($urandom), 8'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule